// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns one 6-bit operand field of a 16-bit-word processor into an operand value. When the operand is written back, it also routes the result to its target. The caller starts an operand with a mode code, a role bit and a skip bit. The role bit says whether the operand is the source operand (role 0) or the destination operand (role 1). The block reads the register file, SP, PC, EX and memory through plain ports, then holds the resolved value with `op_valid` high. While the value is held, a single write strobe stores a result to the operand's target, or drops the write when the mode cannot be written.

Mode codes use a fixed map. Codes 0x00–0x07 name a general register, indexed A, B, C, X, Y, Z, I, J in that order. Codes 0x08–0x0F are memory at that register. Codes 0x10–0x17 are memory at that register plus the word following the instruction. The remaining codes are:

- 0x18: stack
- 0x19: memory at SP
- 0x1A: memory at SP plus the following word
- 0x1B: SP
- 0x1C: PC
- 0x1D: EX
- 0x1E: memory at the following word
- 0x1F: the following word itself
- 0x20–0x3F: small inline constants

Modes that need the following word fetch it from PC+1 in one extra cycle and advance PC by one. A skipped operand still advances PC past its following word, but otherwise has no effect.

Top module: `opnd_resolver`

## Requirements
- R1: After a synchronous active-low reset, `op_valid`, `op_next_word` and every write enable (`rf_we`, `mem_we`, `sp_we`, `pc_we`, `ex_we`) are 0.
- R2: Codes 0x00–0x07 read the register whose index equals the code (A=0 … J=7); a write loads that register with `wr_data`.
- R3: Codes 0x08–0x0F read memory at the selected register's value. Codes 0x10–0x17 read memory at register + mem[PC+1], modulo 2^16. A write stores `wr_data` at the same address.
- R4: Codes 0x10–0x17, 0x1A, 0x1E and 0x1F raise `op_next_word`. When not skipped, such an operand reaches `op_valid` 3 cycles after the start edge, against 2 cycles for every other operand, and PC ends one higher.
- R5: Code 0x18 as source pops: the value is mem[SP], and SP becomes SP+1. As destination, the value is mem[SP-1], and a write sets SP to SP-1 and stores `wr_data` at SP-1, with wrap at zero.
- R6: Code 0x19 reads and writes memory at SP. Code 0x1A reads and writes memory at SP + mem[PC+1].
- R7: Codes 0x1B, 0x1C and 0x1D read SP, PC and EX. A write loads SP or EX with `wr_data`, and loads PC with `wr_data` − 1.
- R8: Code 0x1E reads and writes memory at mem[PC+1]. Code 0x1F yields mem[PC+1] as its value.
- R9: Codes 0x20–0x3F yield the 16-bit value code − 0x21, so 0x20 gives 0xFFFF and 0x3F gives 30.
- R10: With skip set, the value is 0, SP does not move, and a write changes nothing and does not raise `wr_ignored`. A next-word mode still advances PC by one and takes 2 cycles.
- R11: A write to code 0x1F, to an inline constant, or to code 0x18 used as source changes no state and raises `wr_ignored` during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Begin resolving an operand (taken when idle or holding) |
| op_mode | input | 6 | Addressing mode code |
| op_is_dst | input | 1 | 1 = destination operand, 0 = source operand |
| op_skip | input | 1 | Operand belongs to a skipped instruction |
| wr_req | input | 1 | Write strobe while `op_valid` is high |
| wr_data | input | 16 | Value to write back |
| op_valid | output | 1 | Resolved value is held on `op_value` |
| op_value | output | 16 | Resolved operand value |
| op_next_word | output | 1 | Current mode consumes the following word |
| wr_ignored | output | 1 | Write strobe hit a non-writable mode |
| rf_rsel | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_wsel | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| sp_in | input | 16 | Current SP |
| sp_we | output | 1 | SP load enable |
| sp_wdata | output | 16 | New SP |
| pc_in | input | 16 | Current PC |
| pc_we | output | 1 | PC load enable |
| pc_wdata | output | 16 | New PC |
| ex_in | input | 16 | Current EX |
| ex_we | output | 1 | EX load enable |
| ex_wdata | output | 16 | New EX |
| mem_addr | output | 16 | Memory address, shared by reads and writes |
| mem_rdata | input | 16 | Memory read data, combinational from `mem_addr` |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |

## Verification
The assertions rely on three things about the inputs:

- Memory and the register file answer reads combinationally in the same cycle.
- SP, PC and the registers change only through this block's own enables while an operand is in flight.
- `wr_req` is raised only while `op_valid` is high.

The bench meets these conditions. It models memory as a fixed arithmetic function of the address and records each write instead of storing it. It reloads SP, PC, EX and the registers only while the block is idle. It sweeps every mode code under both roles and both skip values. The loaded SP is chosen so that one destination push starts from SP = 0 and wraps.

// File: rtl/opnd_pkg.sv
// Shared types for the operand resolver.
// Assumes: one class per addressing-mode family; the state order has no meaning.
package opnd_pkg;

    typedef enum logic [3:0] {
        CL_REG, CL_IND, CL_IDX, CL_STACK, CL_PEEK, CL_PICK,
        CL_SP, CL_PC, CL_EX, CL_NIND, CL_NLIT, CL_LIT
    } opnd_class_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_NWORD, ST_READ, ST_HOLD
    } opnd_state_e;

endpackage

// File: rtl/opnd_classify.sv
// Maps a mode code onto its addressing class and flags modes that need the
// word following the instruction.
// Assumes: the upper half of the code space is inline constants, and the
// three lowest groups of 2^RSEL_W codes are register-based.
module opnd_classify
    import opnd_pkg::*;
#(
    parameter int MODE_W = 6,
    parameter int RSEL_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    output opnd_class_e       cls,
    output logic              needs_word
);
    localparam int LIT_FIRST = 1 << (MODE_W - 1);
    localparam int GRP_W     = MODE_W - RSEL_W;

    logic [GRP_W-1:0]  grp;
    logic [RSEL_W-1:0] sub;

    assign grp = mode[MODE_W-1:RSEL_W];
    assign sub = mode[RSEL_W-1:0];

    // Class selection: constants first, then register groups, then specials.
    always_comb begin
        if (int'(mode) >= LIT_FIRST) begin
            cls = CL_LIT;
        end else begin
            case (int'(grp))
                0:       cls = CL_REG;
                1:       cls = CL_IND;
                2:       cls = CL_IDX;
                default: begin
                    case (int'(sub))
                        0:       cls = CL_STACK;
                        1:       cls = CL_PEEK;
                        2:       cls = CL_PICK;
                        3:       cls = CL_SP;
                        4:       cls = CL_PC;
                        5:       cls = CL_EX;
                        6:       cls = CL_NIND;
                        default: cls = CL_NLIT;
                    endcase
                end
            endcase
        end
    end

    // Modes that take an extra fetch of the word at PC+1.
    assign needs_word = cls inside {CL_IDX, CL_PICK, CL_NIND, CL_NLIT};

endmodule

// File: rtl/opnd_fetch.sv
// Read path: forms the effective address and selects the operand value.
// Assumes: mem_rdata answers the address produced here in the same cycle;
// nword already holds mem[PC+1] for modes that need it.
module opnd_fetch
    import opnd_pkg::*;
#(
    parameter int DW     = 16,
    parameter int MODE_W = 6
) (
    input  opnd_class_e       cls,
    input  logic              is_dst,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     rf_val,
    input  logic [DW-1:0]     sp,
    input  logic [DW-1:0]     pc,
    input  logic [DW-1:0]     ex,
    input  logic [DW-1:0]     nword,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     addr,
    output logic [DW-1:0]     value
);
    typedef logic [DW-1:0] word_t;
    localparam word_t LIT_BIAS = word_t'((1 << (MODE_W - 1)) + 1);
    localparam word_t ONE      = word_t'(1);

    // Effective address for memory-based classes (wraps at 2^DW).
    always_comb begin
        case (cls)
            CL_IND:   addr = rf_val;
            CL_IDX:   addr = rf_val + nword;
            CL_STACK: addr = is_dst ? sp - ONE : sp;
            CL_PEEK:  addr = sp;
            CL_PICK:  addr = sp + nword;
            CL_NIND:  addr = nword;
            default:  addr = '0;
        endcase
    end

    // Operand value selection.
    always_comb begin
        case (cls)
            CL_REG:  value = rf_val;
            CL_SP:   value = sp;
            CL_PC:   value = pc;
            CL_EX:   value = ex;
            CL_NLIT: value = nword;
            CL_LIT:  value = word_t'(mode) - LIT_BIAS;
            default: value = mem_rdata;
        endcase
    end

endmodule

// File: rtl/opnd_wb.sv
// Write router: turns one write strobe into the enable for the operand's
// target and flags writes to modes that hold no storage.
// Assumes: ptr holds the address latched at read time; for a destination
// push that address is SP-1.
module opnd_wb
    import opnd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          fire,
    input  opnd_class_e   cls,
    input  logic          is_dst,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ptr,
    output logic          rf_we,
    output logic          mem_we,
    output logic          sp_we,
    output logic [DW-1:0] sp_wdata,
    output logic          pc_we,
    output logic [DW-1:0] pc_wdata,
    output logic          ex_we,
    output logic          ignored
);
    typedef logic [DW-1:0] word_t;
    localparam word_t ONE = word_t'(1);

    // Target decode for the write strobe.
    always_comb begin
        rf_we    = 1'b0;
        mem_we   = 1'b0;
        sp_we    = 1'b0;
        sp_wdata = wdata;
        pc_we    = 1'b0;
        pc_wdata = wdata - ONE;
        ex_we    = 1'b0;
        ignored  = 1'b0;
        if (fire) begin
            case (cls)
                CL_REG: rf_we = 1'b1;
                CL_IND, CL_IDX, CL_PEEK, CL_PICK, CL_NIND: mem_we = 1'b1;
                CL_STACK: begin
                    if (is_dst) begin
                        mem_we   = 1'b1;
                        sp_we    = 1'b1;
                        sp_wdata = ptr;
                    end else begin
                        ignored = 1'b1;
                    end
                end
                CL_SP:   sp_we = 1'b1;
                CL_PC:   pc_we = 1'b1;
                CL_EX:   ex_we = 1'b1;
                default: ignored = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/opnd_resolver.sv
// Operand resolver top: sequences the optional next-word fetch, the operand
// read and a single writeback for one addressing-mode code.
// Assumes: SP, PC and the registers change only through this block's
// enables while an operand is in flight; wr_req comes only with op_valid.
module opnd_resolver
    import opnd_pkg::*;
#(
    parameter int DW     = 16,
    parameter int MODE_W = 6,
    parameter int RSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [MODE_W-1:0] op_mode,
    input  logic              op_is_dst,
    input  logic              op_skip,
    input  logic              wr_req,
    input  logic [DW-1:0]     wr_data,
    output logic              op_valid,
    output logic [DW-1:0]     op_value,
    output logic              op_next_word,
    output logic              wr_ignored,
    output logic [RSEL_W-1:0] rf_rsel,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [RSEL_W-1:0] rf_wsel,
    output logic [DW-1:0]     rf_wdata,
    input  logic [DW-1:0]     sp_in,
    output logic              sp_we,
    output logic [DW-1:0]     sp_wdata,
    input  logic [DW-1:0]     pc_in,
    output logic              pc_we,
    output logic [DW-1:0]     pc_wdata,
    input  logic [DW-1:0]     ex_in,
    output logic              ex_we,
    output logic [DW-1:0]     ex_wdata,
    output logic [DW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata
);
    typedef logic [DW-1:0] word_t;
    localparam word_t ONE = word_t'(1);

    opnd_state_e       state_q;
    logic [MODE_W-1:0] mode_q;
    logic              dst_q, skip_q;
    word_t             nword_q, value_q, ptr_q;

    opnd_class_e cls_in, cls_q;
    logic        word_in, word_q;
    word_t       rd_addr, rd_value;
    logic        wr_fire, wb_sp_we, wb_pc_we;
    word_t       wb_sp_wdata, wb_pc_wdata;
    logic        pop_now, skip_adv;

    opnd_classify #(.MODE_W(MODE_W), .RSEL_W(RSEL_W)) u_cls_in (
        .mode(op_mode), .cls(cls_in), .needs_word(word_in));

    opnd_classify #(.MODE_W(MODE_W), .RSEL_W(RSEL_W)) u_cls_q (
        .mode(mode_q), .cls(cls_q), .needs_word(word_q));

    opnd_fetch #(.DW(DW), .MODE_W(MODE_W)) u_fetch (
        .cls(cls_q), .is_dst(dst_q), .mode(mode_q), .rf_val(rf_rdata),
        .sp(sp_in), .pc(pc_in), .ex(ex_in), .nword(nword_q),
        .mem_rdata(mem_rdata), .addr(rd_addr), .value(rd_value));

    opnd_wb #(.DW(DW)) u_wb (
        .fire(wr_fire), .cls(cls_q), .is_dst(dst_q), .wdata(wr_data),
        .ptr(ptr_q), .rf_we(rf_we), .mem_we(mem_we), .sp_we(wb_sp_we),
        .sp_wdata(wb_sp_wdata), .pc_we(wb_pc_we), .pc_wdata(wb_pc_wdata),
        .ex_we(ex_we), .ignored(wr_ignored));

    // Sequencer: idle/hold -> (next-word fetch) -> read -> hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            dst_q   <= 1'b0;
            skip_q  <= 1'b0;
            nword_q <= '0;
            value_q <= '0;
            ptr_q   <= '0;
        end else begin
            case (state_q)
                ST_NWORD: begin
                    nword_q <= mem_rdata;
                    state_q <= ST_READ;
                end
                ST_READ: begin
                    value_q <= skip_q ? '0 : rd_value;
                    ptr_q   <= rd_addr;
                    state_q <= ST_HOLD;
                end
                default: begin
                    if (op_start) begin
                        mode_q  <= op_mode;
                        dst_q   <= op_is_dst;
                        skip_q  <= op_skip;
                        state_q <= (word_in && !op_skip) ? ST_NWORD : ST_READ;
                    end else if (state_q == ST_HOLD && wr_req) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Write strobe is live only while holding an unskipped operand.
    assign wr_fire  = (state_q == ST_HOLD) && wr_req && !skip_q;
    assign pop_now  = (state_q == ST_READ) && (cls_q == CL_STACK) && !dst_q && !skip_q;
    assign skip_adv = (state_q == ST_READ) && skip_q && word_q;

    // PC and SP load sources: next-word advance, pop, or writeback.
    always_comb begin
        pc_we    = wb_pc_we;
        pc_wdata = wb_pc_wdata;
        if (state_q == ST_NWORD || skip_adv) begin
            pc_we    = 1'b1;
            pc_wdata = pc_in + ONE;
        end
        sp_we    = wb_sp_we;
        sp_wdata = wb_sp_wdata;
        if (pop_now) begin
            sp_we    = 1'b1;
            sp_wdata = sp_in + ONE;
        end
    end

    // Shared memory address: fetch word, read operand, then write target.
    always_comb begin
        case (state_q)
            ST_NWORD: mem_addr = pc_in + ONE;
            ST_READ:  mem_addr = rd_addr;
            default:  mem_addr = ptr_q;
        endcase
    end

    assign rf_rsel      = mode_q[RSEL_W-1:0];
    assign rf_wsel      = mode_q[RSEL_W-1:0];
    assign rf_wdata     = wr_data;
    assign ex_wdata     = wr_data;
    assign mem_wdata    = wr_data;
    assign op_valid     = (state_q == ST_HOLD);
    assign op_value     = value_q;
    assign op_next_word = (state_q != ST_IDLE) && word_q;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !op_valid && !op_next_word)
        else $error("outputs active after reset");

    assert_nword_then_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_NWORD |=> state_q == ST_READ && $past(pc_we))
        else $error("next-word fetch did not advance PC");

    assert_pop_moves_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && cls_q == CL_STACK && !dst_q && !skip_q) |-> sp_we)
        else $error("source stack read did not pop");

    assert_mem_write_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> op_valid && wr_req)
        else $error("memory write outside write phase");

    assert_skip_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && skip_q) |-> !(rf_we || mem_we || sp_we || ex_we || wr_ignored))
        else $error("skipped operand touched state");

    assert_ignored_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ignored |-> !(rf_we || mem_we || sp_we || pc_we || ex_we))
        else $error("ignored write raised an enable");

endmodule

// File: tb/opnd_resolver_tb.sv
// Sweeps every mode code under both roles and both skip values, with a
// memory that is a fixed function of the address and a logged write port.
module opnd_resolver_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0, op_is_dst = 1'b0, op_skip = 1'b0, wr_req = 1'b0;
    logic [5:0]  op_mode = '0;
    logic [15:0] wr_data = '0;
    logic        op_valid, op_next_word, wr_ignored;
    logic [15:0] op_value;
    logic [2:0]  rf_rsel, rf_wsel;
    logic [15:0] rf_rdata, rf_wdata, sp_wdata, pc_wdata, ex_wdata, mem_addr, mem_rdata, mem_wdata;
    logic        rf_we, sp_we, pc_we, ex_we, mem_we;

    logic [15:0] rf [8];
    logic [15:0] sp_m = '0, pc_m = '0, ex_m = '0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_rf [8];
    logic [15:0] ld_sp = '0, ld_pc = '0, ld_ex = '0;
    int          wcnt = 0;
    logic [15:0] last_waddr = '0, last_wdata = '0;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] memr(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C3C;
    endfunction

    assign mem_rdata = memr(mem_addr);
    assign rf_rdata  = rf[rf_rsel];

    // State model: loadable from the bench, otherwise updated by the DUT enables.
    always @(posedge clk) begin
        if (ld_en) begin
            rf   <= ld_rf;
            sp_m <= ld_sp;
            pc_m <= ld_pc;
            ex_m <= ld_ex;
        end else begin
            if (rf_we) rf[rf_wsel] <= rf_wdata;
            if (sp_we) sp_m <= sp_wdata;
            if (pc_we) pc_m <= pc_wdata;
            if (ex_we) ex_m <= ex_wdata;
            if (mem_we) begin
                wcnt       <= wcnt + 1;
                last_waddr <= mem_addr;
                last_wdata <= mem_wdata;
            end
        end
    end

    opnd_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_mode(op_mode),
        .op_is_dst(op_is_dst), .op_skip(op_skip), .wr_req(wr_req), .wr_data(wr_data),
        .op_valid(op_valid), .op_value(op_value), .op_next_word(op_next_word),
        .wr_ignored(wr_ignored), .rf_rsel(rf_rsel), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
        .sp_in(sp_m), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .pc_in(pc_m), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .ex_in(ex_m), .ex_we(ex_we), .ex_wdata(ex_wdata),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string rtag(input int m);
        if (m < 8)   return "R2";
        if (m < 24)  return "R3";
        if (m == 24) return "R5";
        if (m < 27)  return "R6";
        if (m < 30)  return "R7";
        if (m < 32)  return "R8";
        return "R9";
    endfunction

    initial begin
        logic [15:0] w, ev, sp0, pc0, sp1, pc1, d, ea;
        logic [15:0] rf_snap [8];
        logic        nw, ign_exp;
        int          lat, w0;

        for (int i = 0; i < 8; i++) ld_rf[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 op_valid in reset", {15'b0, op_valid}, 16'h0);
        chk("R1 enables in reset", {11'b0, rf_we, mem_we, sp_we, pc_we, ex_we}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 next_word after reset", {15'b0, op_next_word}, 16'h0);

        for (int m = 0; m < 64; m++) begin
            for (int dst = 0; dst < 2; dst++) begin
                for (int sk = 0; sk < 2; sk++) begin
                    int k = m * 4 + dst * 2 + sk;
                    for (int i = 0; i < 8; i++) ld_rf[i] = 16'hF000 + 16'(i * 291) + 16'(k);
                    ld_sp = 16'((k - 98) * 257);
                    ld_pc = 16'h8000 + 16'(k * 7);
                    ld_ex = 16'h1234 ^ 16'(k);
                    ld_en = 1'b1;
                    @(negedge clk);
                    ld_en = 1'b0;

                    sp0 = sp_m; pc0 = pc_m;
                    w  = memr(pc0 + 16'd1);
                    nw = (m >= 16 && m <= 23) || m == 26 || m == 30 || m == 31;
                    if (sk) ev = '0;
                    else if (m < 8)   ev = rf[m];
                    else if (m < 16)  ev = memr(rf[m-8]);
                    else if (m < 24)  ev = memr(rf[m-16] + w);
                    else if (m == 24) ev = dst ? memr(sp0 - 16'd1) : memr(sp0);
                    else if (m == 25) ev = memr(sp0);
                    else if (m == 26) ev = memr(sp0 + w);
                    else if (m == 27) ev = sp0;
                    else if (m == 28) ev = pc0;
                    else if (m == 29) ev = ex_m;
                    else if (m == 30) ev = memr(w);
                    else if (m == 31) ev = w;
                    else              ev = 16'(m - 33);

                    op_mode = 6'(m); op_is_dst = dst[0]; op_skip = sk[0]; op_start = 1'b1;
                    @(negedge clk);
                    op_start = 1'b0;
                    lat = 1;
                    while (!op_valid && lat < 8) begin
                        @(negedge clk);
                        lat++;
                    end
                    if (sk) begin
                        chk("R10 skipped value", op_value, ev);
                        chk("R10 skipped latency", 16'(lat), 16'd2);
                    end else begin
                        chk({rtag(m), " value"}, op_value, ev);
                        chk("R4 latency", 16'(lat), (nw ? 16'd3 : 16'd2));
                    end
                    chk("R4 next_word flag", {15'b0, op_next_word}, {15'b0, nw});
                    chk("R4 PC after read", pc_m, pc0 + (nw ? 16'd1 : 16'd0));
                    chk("R5 SP after read", sp_m,
                        (m == 24 && dst == 0 && sk == 0) ? sp0 + 16'd1 : sp0);

                    sp1 = sp_m; pc1 = pc_m; rf_snap = rf; w0 = wcnt;
                    d = 16'hC000 ^ 16'(k * 261);
                    ign_exp = !sk && (m >= 31 || (m == 24 && dst == 0));
                    wr_data = d; wr_req = 1'b1;
                    #1;
                    chk("R11 wr_ignored", {15'b0, wr_ignored}, {15'b0, ign_exp});
                    @(negedge clk);
                    wr_req = 1'b0;

                    if (sk || ign_exp) begin
                        chk(sk ? "R10 no reg change" : "R11 no reg change",
                            {15'b0, rf == rf_snap}, 16'h1);
                        chk(sk ? "R10 no SP change" : "R11 no SP change", sp_m, sp1);
                        chk(sk ? "R10 no PC change" : "R11 no PC change", pc_m, pc1);
                        chk(sk ? "R10 no mem write" : "R11 no mem write", 16'(wcnt), 16'(w0));
                    end else if (m < 8) begin
                        chk("R2 register write", rf[m], d);
                    end else if (m == 27) begin
                        chk("R7 SP write", sp_m, d);
                    end else if (m == 28) begin
                        chk("R7 PC write", pc_m, d - 16'd1);
                    end else if (m == 29) begin
                        chk("R7 EX write", ex_m, d);
                    end else begin
                        if (m < 16)       ea = rf_snap[m-8];
                        else if (m < 24)  ea = rf_snap[m-16] + w;
                        else if (m == 24) ea = sp1 - 16'd1;
                        else if (m == 25) ea = sp1;
                        else if (m == 26) ea = sp1 + w;
                        else              ea = w;
                        chk({rtag(m), " write count"}, 16'(wcnt), 16'(w0 + 1));
                        chk({rtag(m), " write address"}, last_waddr, ea);
                        chk({rtag(m), " write data"}, last_wdata, d);
                        if (m == 24) chk("R5 push SP", sp_m, sp1 - 16'd1);
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule